// File: doc/BRIEF.md
# APB Register Bank with Wait States, Byte Strobes and Access Protection

This block is a small bank of 32-bit registers that sits behind an APB peripheral port. A bus master reads and writes whole words. Writes can be limited to chosen bytes through the per-lane strobe. The bank stretches every transfer by a fixed number of wait cycles, set by a parameter. During those cycles it holds the ready response low, which models a slow peripheral.

Each access is checked against two rules. The word address must fall inside the bank. One register (by default the highest one) is a protected register, and only a secure, privileged access may reach it. An access that breaks either rule ends with an error response. It changes no register, and on a read it returns zero. No register write ever happens outside the cycle that completes the transfer.

Top module: `apb_regbank`

## Requirements
- R1: While `presetn` is low, every register reads back as zero once reset is released, and `pready`, `pslverr` and `prdata` are all low.
- R2: `pready` is high only in an access cycle (`psel` and `penable` high), and it first rises after WAIT_STATES access cycles. A transfer therefore lasts WAIT_STATES+2 cycles, counting from the setup cycle.
- R3: A write updates byte lane i (bits 8i+7..8i) only when `pstrb[i]` is 1. Lanes whose strobe is 0 keep their previous value. A write with all strobes 0 changes nothing.
- R4: A read ignores `pstrb` and returns the whole 32-bit word.
- R5: `prdata` is zero in every cycle except the completing cycle of a read that has no error.
- R6: The word index is `paddr[ADDR_W-1:2]`. An index of NUM_REGS or above is unmapped. An access to it completes with `pslverr` high and changes no register.
- R7: Register SECURE_IDX (default 7, byte address 0x1C) needs `pprot[0]`=1 (privileged) and `pprot[1]`=0 (secure). Any other access to it ends with `pslverr`, leaves it unchanged, and reads as zero. `pprot[2]` (instruction/data) has no effect.
- R8: `paddr[1:0]` does not affect which register is selected.
- R9: `pslverr` is high only in a cycle where `pready` is high. It is low in all wait cycles and all idle cycles.
- R10: `presetn` clears the bank and the wait counter at once, without a clock edge, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, rising edge |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Marks the access phase |
| paddr | input | ADDR_W | Byte address |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write enables |
| pprot | input | 3 | Bit 0 privileged, bit 1 non-secure, bit 2 instruction |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer completes when high |
| pslverr | output | 1 | Error response, valid with `pready` |

## Verification
The assertions assume that the master follows the two-phase handshake. It raises `psel` for one setup cycle before `penable`, and it holds `psel`, `penable`, the address, the direction, the protection bits and the strobes steady until `pready` has been high for one cycle. The wait-cycle rule depends on this, because the checker counts the access cycles of one transfer. The bench drives every transfer through one pair of tasks that keep to this order. They always return to idle between transfers, and they change inputs only on the falling clock edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Protection attribute bits as carried on the bus.
  typedef struct packed {
    logic instr;    // bit 2
    logic nonsec;   // bit 1
    logic priv;     // bit 0
  } prot_t;

  // True when an access does not meet the secure-and-privileged rule.
  function automatic logic prot_denied(input prot_t p);
    return (!p.priv) || p.nonsec;
  endfunction

  // Merge one byte lane: keep the old byte unless the lane is enabled.
  function automatic logic [7:0] lane_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b,
                                            input logic       en);
    return en ? new_b : old_b;
  endfunction

endpackage

// File: rtl/regbank_wait.sv
module regbank_wait #(
  parameter int WAIT_STATES = 2
) (
  input  logic pclk,
  input  logic presetn,
  input  logic psel,
  input  logic penable,
  output logic ready_o
);
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             in_access;

  assign in_access = psel && penable;
  assign ready_o   = in_access && (cnt_q == CNT_W'(WAIT_STATES));

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)
      cnt_q <= '0;
    else if (in_access && !ready_o)
      cnt_q <= cnt_q + 1'b1;
    else
      cnt_q <= '0;
  end
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_REGS   = 8,
  parameter int SECURE_IDX = 7
) (
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [2:0]                  pprot,
  output logic [$clog2(NUM_REGS)-1:0] sel_o,
  output logic                        unmapped_o,
  output logic                        prot_fail_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] word_idx;
  prot_t            attr;
  logic [2:0]       unused_bits;

  assign word_idx    = paddr[ADDR_W-1:2];
  assign attr        = prot_t'(pprot);
  assign unused_bits = {paddr[1:0], attr.instr};

  assign unmapped_o  = (32'(word_idx) >= NUM_REGS);
  assign sel_o       = word_idx[SEL_W-1:0];
  assign prot_fail_o = !unmapped_o && (32'(word_idx) == SECURE_IDX) && prot_denied(attr);
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic                               pclk,
  input  logic                               presetn,
  input  logic                               we,
  input  logic [$clog2(NUM_REGS)-1:0]        sel,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [DATA_W/8-1:0]                strb,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    words_o
);
  localparam int LANES = DATA_W / 8;

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)
          mem_q[r][8*b +: 8] <= '0;
        else if (we && (32'(sel) == r))
          mem_q[r][8*b +: 8] <= lane_merge(mem_q[r][8*b +: 8], wdata[8*b +: 8], strb[b]);
      end
    end
  end

  assign words_o = mem_q;
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int NUM_REGS    = 8,
  parameter int WAIT_STATES = 2,
  parameter int SECURE_IDX  = 7
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic                pwrite,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [2:0]          pprot,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  output logic                pslverr
);
  localparam int SEL_W = $clog2(NUM_REGS);

  // Named internal events, visible to the bound checker.
  logic                            complete;
  logic                            unmapped;
  logic                            prot_fail;
  logic                            access_err;
  logic                            wr_commit;
  logic [SEL_W-1:0]                sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]               secure_word;

  regbank_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .ready_o (complete)
  );

  regbank_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SECURE_IDX(SECURE_IDX)
  ) u_dec (
    .paddr       (paddr),
    .pprot       (pprot),
    .sel_o       (sel),
    .unmapped_o  (unmapped),
    .prot_fail_o (prot_fail)
  );

  assign access_err = unmapped || prot_fail;
  assign wr_commit  = complete && pwrite && !access_err;

  regbank_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .pclk    (pclk),
    .presetn (presetn),
    .we      (wr_commit),
    .sel     (sel),
    .wdata   (pwdata),
    .strb    (pstrb),
    .words_o (words)
  );

  assign secure_word = words[SECURE_IDX];

  assign pready  = complete;
  assign pslverr = complete && access_err;
  assign prdata  = (complete && !pwrite && !access_err) ? words[sel] : '0;
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
  parameter int DATA_W      = 32,
  parameter int WAIT_STATES = 2
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] prdata,
  input logic              complete,
  input logic              unmapped,
  input logic              prot_fail,
  input logic [DATA_W-1:0] secure_word
);
  // Independent count of the access cycles that have not yet completed.
  int unsigned acc_seen;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)                          acc_seen <= 0;
    else if (psel && penable && !pready)   acc_seen <= acc_seen + 1;
    else                                   acc_seen <= 0;
  end

  AST_READY_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (psel && penable)); // R2
  AST_WAIT_LENGTH: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (acc_seen == WAIT_STATES)); // R2
  AST_ERR_NEEDS_READY: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> pready); // R9
  AST_RDATA_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    !pready |-> (prdata == '0)); // R5
  AST_UNMAPPED_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (complete && unmapped) |-> pslverr); // R6
  AST_SECURE_HELD: assert property (@(posedge pclk) disable iff (!presetn)
    (complete && prot_fail) |=> $stable(secure_word)); // R7
  AST_RESET_QUIET: assert property (@(posedge pclk)
    !presetn |-> (!pready && !pslverr)); // R1
endmodule

bind apb_regbank regbank_checker #(
  .DATA_W(DATA_W), .WAIT_STATES(WAIT_STATES)
) u_chk (
  .pclk        (pclk),
  .presetn     (presetn),
  .psel        (psel),
  .penable     (penable),
  .pready      (pready),
  .pslverr     (pslverr),
  .prdata      (prdata),
  .complete    (complete),
  .unmapped    (unmapped),
  .prot_fail   (prot_fail),
  .secure_word (secure_word)
);

// File: tb/tb_apb_regbank.sv
module tb_apb_regbank;
  localparam int WAITS = 2;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [2:0]  pprot = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 pclk = ~pclk;   // 50 MHz

  apb_regbank dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb),
    .pprot(pprot), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full transfer; returns data, error flag and length in cycles.
  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, input logic [2:0] p,
                      output logic [31:0] rd, output logic err, output int cyc);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s; pprot = p;
    cyc = 1;
    @(negedge pclk);
    penable = 1'b1;
    cyc++;
    #1;
    while (!pready && cyc < 50) begin
      check("R9 wait err", {31'b0, pslverr}, 32'd0);
      check("R5 wait data", prdata, 32'd0);
      @(negedge pclk); #1;
      cyc++;
    end
    rd = prdata; err = pslverr;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [2:0]  prot;
    logic [31:0] exp;
    logic        exp_err;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'hDEADBEEF, 4'hF, 3'b001, 32'h0,        1'b0}, // R3 full write
    '{1'b0, 8'h00, 32'h0,        4'hF, 3'b001, 32'hDEADBEEF, 1'b0},
    '{1'b1, 8'h00, 32'h11223344, 4'h5, 3'b001, 32'h0,        1'b0}, // R3 lanes 0,2
    '{1'b0, 8'h00, 32'h0,        4'h0, 3'b001, 32'hDE22BE44, 1'b0}, // R4 strobe ignored
    '{1'b1, 8'h06, 32'h0000A5A5, 4'hF, 3'b001, 32'h0,        1'b0}, // R8 low bits
    '{1'b0, 8'h04, 32'h0,        4'h3, 3'b001, 32'h0000A5A5, 1'b0}, // R8
    '{1'b0, 8'h07, 32'h0,        4'h0, 3'b001, 32'h0000A5A5, 1'b0}, // R8
    '{1'b1, 8'h20, 32'h12345678, 4'hF, 3'b001, 32'h0,        1'b1}, // R6 unmapped
    '{1'b0, 8'h20, 32'h0,        4'hF, 3'b001, 32'h0,        1'b1}, // R6
    '{1'b1, 8'h1C, 32'hFFFFFFFF, 4'hF, 3'b000, 32'h0,        1'b1}, // R7 unprivileged
    '{1'b1, 8'h1C, 32'hFFFFFFFF, 4'hF, 3'b011, 32'h0,        1'b1}, // R7 non-secure
    '{1'b0, 8'h1C, 32'h0,        4'hF, 3'b001, 32'h0,        1'b0}, // R7 unchanged
    '{1'b1, 8'h1C, 32'hCAFEF00D, 4'hC, 3'b001, 32'h0,        1'b0}, // R7 allowed, R3
    '{1'b0, 8'h1C, 32'h0,        4'hF, 3'b010, 32'h0,        1'b1}, // R7 read denied
    '{1'b0, 8'h1C, 32'h0,        4'hF, 3'b101, 32'hCAFE0000, 1'b0}, // R7 instr bit ignored
    '{1'b1, 8'h08, 32'hFFFFFFFF, 4'h0, 3'b001, 32'h0,        1'b0}, // R3 no strobes
    '{1'b0, 8'h08, 32'h0,        4'hF, 3'b001, 32'h0,        1'b0}  // R3
  };

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    int          cyc;

    // R1: outputs quiet during reset.
    #35;
    check("R1 pready in reset",  {31'b0, pready},  32'd0);
    check("R1 pslverr in reset", {31'b0, pslverr}, 32'd0);
    check("R1 prdata in reset",  prdata, 32'd0);
    @(negedge pclk); presetn = 1'b1;

    // R1: all registers clear after reset.
    for (int i = 0; i < 8; i++) begin
      xfer(1'b0, 8'(i * 4), 32'h0, 4'hF, 3'b001, rd, err, cyc);
      check("R1 reset value", rd, 32'h0);
    end

    // Table walk: R2 length, R3..R8 data and errors.
    for (int v = 0; v < NV; v++) begin
      xfer(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].strb, VECS[v].prot, rd, err, cyc);
      check("R2 transfer length", 32'(cyc), 32'(WAITS + 2));
      check("R6/R7 error flag", {31'b0, err}, {31'b0, VECS[v].exp_err});
      if (!VECS[v].wr) check("R4/R5 read data", rd, VECS[v].exp);
    end

    // R5/R9: idle outputs.
    @(negedge pclk); #1;
    check("R5 idle prdata", prdata, 32'd0);
    check("R9 idle pslverr", {31'b0, pslverr}, 32'd0);

    // R10: reset asserted inside a transfer.
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h5555AAAA;
    pstrb = 4'hF; pprot = 3'b001;
    @(negedge pclk); penable = 1'b1;
    #3 presetn = 1'b0;
    #1 check("R10 pready in reset", {31'b0, pready}, 32'd0);
    @(negedge pclk); psel = 1'b0; penable = 1'b0;
    @(negedge pclk); presetn = 1'b1;
    xfer(1'b0, 8'h00, 32'h0, 4'hF, 3'b001, rd, err, cyc);
    check("R10 reg0 cleared", rd, 32'h0);
    check("R10 length after reset", 32'(cyc), 32'(WAITS + 2));
    xfer(1'b0, 8'h1C, 32'h0, 4'hF, 3'b001, rd, err, cyc);
    check("R10 secure reg cleared", rd, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule